// File: doc/BRIEF.md
# Exception State and System Register Unit

This unit holds the processor's dedicated 32-bit system registers. It also performs the state save when an ordinary exception, a maskable interrupt, an NMI or a duplexed exception is taken. Software reaches the registers through a 5-bit register number. A read port returns the selected register in the same cycle. A write port commits on the next clock edge. These are the ports that move-to and move-from system register instructions use.

Two event classes each have their own PC/PSW save pair. They share one cause register that is split into two 16-bit halves, and each class owns one half. A trap-address register is compared with the current PC, and a match raises a trap strobe. The unit also drives the constant PC value used at reset.

All ports are plain control and register pins. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `sysreg_unit`

## Requirements
- R1: After reset, both save pairs, the cause register and registers 7, 24 and 25 read zero, and `reset_pc` is 32'hFFFF_FFF0 (bit 0 always 0).
- R2: When `exc_take` is high at a clock edge, the following values appear from the next cycle:
  - `exc_pc_q` takes `cur_pc` with bit 0 cleared.
  - `exc_psw_q` takes `cur_psw`.
  - `cause_q[15:0]` takes `exc_code`.
  - `cause_q[31:16]` keeps its value unless `fat_take` or a software write to number 4 also applies.
- R3: When `fat_take` is high at a clock edge, the following values appear from the next cycle:
  - `fat_pc_q` takes `cur_pc` with bit 0 cleared.
  - `fat_psw_q` takes `cur_psw`.
  - `cause_q[31:16]` takes `fat_code`.
  - `cause_q[15:0]` keeps its value unless `exc_take` or a software write to number 4 also applies.
- R4: Each class has one save pair. A second ordinary event overwrites numbers 0/1. An ordinary event leaves numbers 2/3 unchanged, and a fatal event leaves numbers 0/1 unchanged.
- R5: Register numbers map as follows, and `rd_data` shows the selected register combinationally:
  - 0: exception PC
  - 1: exception PSW
  - 2: fatal PC
  - 3: fatal PSW
  - 4: cause
  - 5: status word
  - 6: identification
  - 7: float control
  - 24: cache control
  - 25: trap address
- R6: A write with `wr_en` high updates numbers 0–4, 7, 24 and 25 at the clock edge. Writes to numbers 0 and 2 store bit 0 as 0.
- R7: Number 6 always reads `ID_VALUE` (default 32'h0000_5A10), and writes to it are ignored.
- R8: Numbers 8–23 and 26–31 read zero, and writes to them change no register.
- R9: Number 5 reads the `cur_psw` input, and writes to number 5 are ignored by this unit.
- R10: When an event save and a software write target the same register in one cycle, the event value is stored. For the cause register this is decided per half, so the half that no event claims takes `wr_data`.
- R11: `trap_hit` is high in the same cycle exactly when `pc_vld` is high and `cur_pc` equals the trap-address register.
- R12: When `exc_take` and `fat_take` are high together, both save pairs and both cause halves are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software register write strobe |
| wr_num | input | 5 | Register number for write |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Register number for read |
| rd_data | output | 32 | Read data (combinational) |
| exc_take | input | 1 | Ordinary exception / maskable interrupt taken |
| exc_code | input | 16 | Cause code for ordinary event |
| fat_take | input | 1 | NMI / duplexed exception taken |
| fat_code | input | 16 | Cause code for fatal event |
| cur_pc | input | 32 | Current program counter |
| cur_psw | input | 32 | Current program status word |
| pc_vld | input | 1 | Qualifies `cur_pc` for trap compare |
| trap_hit | output | 1 | Address trap match strobe |
| reset_pc | output | 32 | PC value used at reset |
| exc_pc_q | output | 32 | Saved PC, ordinary class |
| exc_psw_q | output | 32 | Saved PSW, ordinary class |
| fat_pc_q | output | 32 | Saved PC, fatal class |
| fat_psw_q | output | 32 | Saved PSW, fatal class |
| cause_q | output | 32 | Split cause register |

## Verification
The bench targets the following corner cases, and describes what a wrong design would show in each:

- **Shared cause register.** Two events of different classes are saved one after the other. A design that wrote the full 32 bits on either event would wipe the other class's code.
- **Same-cycle collisions.** A software write to a saved PC and a write to the cause register are each issued in the same cycle as an event. A wrong priority would leave the software value in the register, or would drop the half of the cause register that no event claimed.
- **Odd PC values.** Odd PC values are sent through both the save path and the write path. A missing bit-0 clear shows up as an odd saved PC.
- **Ignored numbers.** Writes go to reserved numbers, the identification number and the status number, and a decode that aliased them would corrupt a live register or return a nonzero read.
- **Trap compare.** The compare is probed with the PC equal to the trap address, off by two, and not qualified by `pc_vld`.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int SR_W    = 32;
  localparam int SR_NW   = 5;
  localparam int SR_CW   = 16;

  // register numbers; decoded by move-to/from instructions
  localparam logic [SR_NW-1:0] N_EXC_PC   = 5'd0;
  localparam logic [SR_NW-1:0] N_EXC_PSW  = 5'd1;
  localparam logic [SR_NW-1:0] N_FAT_PC   = 5'd2;
  localparam logic [SR_NW-1:0] N_FAT_PSW  = 5'd3;
  localparam logic [SR_NW-1:0] N_CAUSE    = 5'd4;
  localparam logic [SR_NW-1:0] N_STATUS   = 5'd5;
  localparam logic [SR_NW-1:0] N_IDENT    = 5'd6;
  localparam logic [SR_NW-1:0] N_FPCTL    = 5'd7;
  localparam logic [SR_NW-1:0] N_CACHECTL = 5'd24;
  localparam logic [SR_NW-1:0] N_TRAPADDR = 5'd25;
endpackage

// File: rtl/sr_save_pair.sv
module sr_save_pair #(
  parameter int W = 32,
  parameter int NW = 5,
  parameter logic [NW-1:0] PC_NUM = '0,
  parameter logic [NW-1:0] PSW_NUM = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_take,
  input  logic [W-1:0]  ev_pc,
  input  logic [W-1:0]  ev_psw,
  input  logic          wr_en,
  input  logic [NW-1:0] wr_num,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  pc_q,
  output logic [W-1:0]  psw_q
);
  localparam logic [W-1:0] PC_MASK = {{(W-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      psw_q <= '0;
    end else if (ev_take) begin
      pc_q  <= ev_pc & PC_MASK;
      psw_q <= ev_psw;
    end else if (wr_en) begin
      if (wr_num == PC_NUM)  pc_q  <= wr_data & PC_MASK;
      if (wr_num == PSW_NUM) psw_q <= wr_data;
    end
  end
endmodule

// File: rtl/sr_cause.sv
module sr_cause #(
  parameter int CW = 16,
  parameter int NW = 5,
  parameter logic [NW-1:0] NUM = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_take,
  input  logic [CW-1:0]   exc_code,
  input  logic            fat_take,
  input  logic [CW-1:0]   fat_code,
  input  logic            wr_en,
  input  logic [NW-1:0]   wr_num,
  input  logic [2*CW-1:0] wr_data,
  output logic [2*CW-1:0] cause_q
);
  logic sw_hit;
  assign sw_hit = wr_en && (wr_num == NUM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else begin
      if (exc_take)    cause_q[CW-1:0] <= exc_code;
      else if (sw_hit) cause_q[CW-1:0] <= wr_data[CW-1:0];
      if (fat_take)    cause_q[2*CW-1:CW] <= fat_code;
      else if (sw_hit) cause_q[2*CW-1:CW] <= wr_data[2*CW-1:CW];
    end
  end
endmodule

// File: rtl/sr_word.sv
module sr_word #(
  parameter int W = 32,
  parameter int NW = 5,
  parameter logic [NW-1:0] NUM = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NW-1:0] wr_num,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                        q <= '0;
    else if (wr_en && wr_num == NUM)   q <= wr_data;
  end
endmodule

// File: rtl/sr_read_mux.sv
module sr_read_mux
  import sysreg_pkg::*;
#(
  parameter int W = 32,
  parameter int NW = 5,
  parameter logic [W-1:0] ID_VALUE = '0
) (
  input  logic [NW-1:0] rd_num,
  input  logic [W-1:0]  exc_pc,
  input  logic [W-1:0]  exc_psw,
  input  logic [W-1:0]  fat_pc,
  input  logic [W-1:0]  fat_psw,
  input  logic [W-1:0]  cause,
  input  logic [W-1:0]  status,
  input  logic [W-1:0]  fpctl,
  input  logic [W-1:0]  cachectl,
  input  logic [W-1:0]  trapaddr,
  output logic [W-1:0]  rd_data
);
  always_comb begin
    case (rd_num)
      N_EXC_PC:   rd_data = exc_pc;
      N_EXC_PSW:  rd_data = exc_psw;
      N_FAT_PC:   rd_data = fat_pc;
      N_FAT_PSW:  rd_data = fat_psw;
      N_CAUSE:    rd_data = cause;
      N_STATUS:   rd_data = status;
      N_IDENT:    rd_data = ID_VALUE;
      N_FPCTL:    rd_data = fpctl;
      N_CACHECTL: rd_data = cachectl;
      N_TRAPADDR: rd_data = trapaddr;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sysreg_unit.sv
module sysreg_unit
  import sysreg_pkg::*;
#(
  parameter logic [SR_W-1:0] ID_VALUE = 32'h0000_5A10,
  parameter logic [SR_W-1:0] RESET_PC = 32'hFFFF_FFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SR_NW-1:0] wr_num,
  input  logic [SR_W-1:0]  wr_data,
  input  logic [SR_NW-1:0] rd_num,
  output logic [SR_W-1:0]  rd_data,
  input  logic             exc_take,
  input  logic [SR_CW-1:0] exc_code,
  input  logic             fat_take,
  input  logic [SR_CW-1:0] fat_code,
  input  logic [SR_W-1:0]  cur_pc,
  input  logic [SR_W-1:0]  cur_psw,
  input  logic             pc_vld,
  output logic             trap_hit,
  output logic [SR_W-1:0]  reset_pc,
  output logic [SR_W-1:0]  exc_pc_q,
  output logic [SR_W-1:0]  exc_psw_q,
  output logic [SR_W-1:0]  fat_pc_q,
  output logic [SR_W-1:0]  fat_psw_q,
  output logic [SR_W-1:0]  cause_q
);
  localparam int NPAIR = 2;
  localparam int NCTL  = 3;
  localparam logic [NCTL*SR_NW-1:0] CTL_NUMS = {N_TRAPADDR, N_CACHECTL, N_FPCTL};
  localparam logic [NPAIR*SR_NW-1:0] PC_NUMS  = {N_FAT_PC, N_EXC_PC};
  localparam logic [NPAIR*SR_NW-1:0] PSW_NUMS = {N_FAT_PSW, N_EXC_PSW};

  logic [NPAIR-1:0]           ev_take;
  logic [NPAIR-1:0][SR_W-1:0] pair_pc;
  logic [NPAIR-1:0][SR_W-1:0] pair_psw;
  logic [NCTL-1:0][SR_W-1:0]  ctl_q;

  assign ev_take  = {fat_take, exc_take};
  assign reset_pc = {RESET_PC[SR_W-1:1], 1'b0};

  // one save pair per event class
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    sr_save_pair #(
      .W(SR_W), .NW(SR_NW),
      .PC_NUM(PC_NUMS[g*SR_NW +: SR_NW]),
      .PSW_NUM(PSW_NUMS[g*SR_NW +: SR_NW])
    ) u_pair (
      .clk(clk), .rst_n(rst_n), .ev_take(ev_take[g]),
      .ev_pc(cur_pc), .ev_psw(cur_psw),
      .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
      .pc_q(pair_pc[g]), .psw_q(pair_psw[g])
    );
  end

  // plain software-owned control words
  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    sr_word #(.W(SR_W), .NW(SR_NW), .NUM(CTL_NUMS[g*SR_NW +: SR_NW])) u_word (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num),
      .wr_data(wr_data), .q(ctl_q[g])
    );
  end

  sr_cause #(.CW(SR_CW), .NW(SR_NW), .NUM(N_CAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n),
    .exc_take(exc_take), .exc_code(exc_code),
    .fat_take(fat_take), .fat_code(fat_code),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .cause_q(cause_q)
  );

  sr_read_mux #(.W(SR_W), .NW(SR_NW), .ID_VALUE(ID_VALUE)) u_rmux (
    .rd_num(rd_num),
    .exc_pc(pair_pc[0]), .exc_psw(pair_psw[0]),
    .fat_pc(pair_pc[1]), .fat_psw(pair_psw[1]),
    .cause(cause_q), .status(cur_psw),
    .fpctl(ctl_q[0]), .cachectl(ctl_q[1]), .trapaddr(ctl_q[2]),
    .rd_data(rd_data)
  );

  assign trap_hit  = pc_vld && (cur_pc == ctl_q[2]);

  assign exc_pc_q  = pair_pc[0];
  assign exc_psw_q = pair_psw[0];
  assign fat_pc_q  = pair_pc[1];
  assign fat_psw_q = pair_psw[1];
endmodule

// File: rtl/sysreg_unit_chk.sv
module sysreg_unit_chk #(
  parameter logic [31:0] ID_VALUE = 32'h0000_5A10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_num,
  input logic [31:0] wr_data,
  input logic [4:0]  rd_num,
  input logic [31:0] rd_data,
  input logic        exc_take,
  input logic [15:0] exc_code,
  input logic        fat_take,
  input logic [15:0] fat_code,
  input logic [31:0] cur_pc,
  input logic [31:0] cur_psw,
  input logic        pc_vld,
  input logic        trap_hit,
  input logic [31:0] exc_pc_q,
  input logic [31:0] exc_psw_q,
  input logic [31:0] fat_pc_q,
  input logic [31:0] fat_psw_q,
  input logic [31:0] cause_q
);
  // R2
  exc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (exc_pc_q == {$past(cur_pc[31:1]), 1'b0}) && (exc_psw_q == $past(cur_psw))
                 && (cause_q[15:0] == $past(exc_code)));
  // R3
  fat_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fat_take |=> (fat_pc_q == {$past(cur_pc[31:1]), 1'b0}) && (fat_psw_q == $past(cur_psw))
                 && (cause_q[31:16] == $past(fat_code)));
  // R4
  exc_keeps_fat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !fat_take && !(wr_en && wr_num inside {5'd2, 5'd3, 5'd4}))
      |=> $stable(fat_pc_q) && $stable(fat_psw_q) && $stable(cause_q[31:16]));
  // R4
  fat_keeps_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fat_take && !exc_take && !(wr_en && wr_num inside {5'd0, 5'd1, 5'd4}))
      |=> $stable(exc_pc_q) && $stable(exc_psw_q) && $stable(cause_q[15:0]));
  // R6
  sw_psw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num == 5'd1 && !exc_take) |=> exc_psw_q == $past(wr_data));
  // R6
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_pc_q[0] && !fat_pc_q[0]);
  // R7
  ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num == 5'd6) |-> rd_data == ID_VALUE);
  // R8
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_num >= 5'd8 && rd_num <= 5'd23) || rd_num >= 5'd26) |-> rd_data == 32'd0);
  // R9
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num == 5'd5) |-> rd_data == cur_psw);
  // R11
  trap_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |-> pc_vld);
endmodule

bind sysreg_unit sysreg_unit_chk #(.ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
  .rd_num(rd_num), .rd_data(rd_data), .exc_take(exc_take), .exc_code(exc_code),
  .fat_take(fat_take), .fat_code(fat_code), .cur_pc(cur_pc), .cur_psw(cur_psw),
  .pc_vld(pc_vld), .trap_hit(trap_hit), .exc_pc_q(exc_pc_q), .exc_psw_q(exc_psw_q),
  .fat_pc_q(fat_pc_q), .fat_psw_q(fat_psw_q), .cause_q(cause_q)
);

// File: tb/sysreg_unit_bench.sv
`timescale 1ns/1ps
module sysreg_unit_bench;
  localparam logic [31:0] EXP_ID = 32'h0000_5A10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [4:0] wr_num = 0; logic [31:0] wr_data = 0;
  logic [4:0] rd_num = 0; logic [31:0] rd_data;
  logic exc_take = 0; logic [15:0] exc_code = 0;
  logic fat_take = 0; logic [15:0] fat_code = 0;
  logic [31:0] cur_pc = 0, cur_psw = 0; logic pc_vld = 0;
  logic trap_hit; logic [31:0] reset_pc;
  logic [31:0] exc_pc_q, exc_psw_q, fat_pc_q, fat_psw_q, cause_q;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysreg_unit u_sysreg_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .rd_num(rd_num), .rd_data(rd_data), .exc_take(exc_take), .exc_code(exc_code),
    .fat_take(fat_take), .fat_code(fat_code), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .pc_vld(pc_vld), .trap_hit(trap_hit), .reset_pc(reset_pc),
    .exc_pc_q(exc_pc_q), .exc_psw_q(exc_psw_q), .fat_pc_q(fat_pc_q),
    .fat_psw_q(fat_psw_q), .cause_q(cause_q)
  );

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [4:0] num, logic [31:0] exp);
    rd_num = num; #1;
    cmp(tag, rd_data, exp);
  endtask

  task automatic sw_wr(logic [4:0] num, logic [31:0] data);
    @(negedge clk); wr_en = 1; wr_num = num; wr_data = data;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset();
    cmp("R1 exc_pc", exc_pc_q, 0);  cmp("R1 exc_psw", exc_psw_q, 0);
    cmp("R1 fat_pc", fat_pc_q, 0);  cmp("R1 fat_psw", fat_psw_q, 0);
    cmp("R1 cause", cause_q, 0);    cmp("R1 reset_pc", reset_pc, 32'hFFFF_FFF0);
    rd_chk("R1 num7", 5'd7, 0); rd_chk("R1 num24", 5'd24, 0); rd_chk("R1 num25", 5'd25, 0);
  endtask

  task automatic t_exc();
    @(negedge clk); cur_pc = 32'h0000_1235; cur_psw = 32'hA5; exc_code = 16'h0040; exc_take = 1;
    @(negedge clk); exc_take = 0;
    cmp("R2 exc_pc", exc_pc_q, 32'h0000_1234); cmp("R2 exc_psw", exc_psw_q, 32'hA5);
    cmp("R2 cause", cause_q, 32'h0000_0040);
    @(negedge clk); cur_pc = 32'h8000_0010; cur_psw = 32'h3; exc_code = 16'h0123; exc_take = 1;
    @(negedge clk); exc_take = 0;
    cmp("R4 overwrite pc", exc_pc_q, 32'h8000_0010); cmp("R4 overwrite psw", exc_psw_q, 32'h3);
    cmp("R4 fat untouched", fat_pc_q, 0); cmp("R2 cause2", cause_q, 32'h0000_0123);
  endtask

  task automatic t_fat();
    @(negedge clk); cur_pc = 32'h0000_7777; cur_psw = 32'hF00F; fat_code = 16'hFFF0; fat_take = 1;
    @(negedge clk); fat_take = 0;
    cmp("R3 fat_pc", fat_pc_q, 32'h0000_7776); cmp("R3 fat_psw", fat_psw_q, 32'hF00F);
    cmp("R3 cause halves", cause_q, 32'hFFF0_0123);
    cmp("R4 exc untouched", exc_pc_q, 32'h8000_0010);
  endtask

  task automatic t_both();
    @(negedge clk); cur_pc = 32'h4444_0002; cur_psw = 32'h11;
    exc_code = 16'h0AAA; fat_code = 16'h0BBB; exc_take = 1; fat_take = 1;
    @(negedge clk); exc_take = 0; fat_take = 0;
    cmp("R12 exc_pc", exc_pc_q, 32'h4444_0002); cmp("R12 fat_pc", fat_pc_q, 32'h4444_0002);
    cmp("R12 fat_psw", fat_psw_q, 32'h11);      cmp("R12 cause", cause_q, 32'h0BBB_0AAA);
  endtask

  task automatic t_sw();
    sw_wr(5'd0, 32'hDEAD_BEEF); cmp("R6 exc_pc bit0", exc_pc_q, 32'hDEAD_BEEE);
    sw_wr(5'd2, 32'h1111_1113);
    sw_wr(5'd1, 32'hCAFE_0001); sw_wr(5'd3, 32'h0BAD_F00D);
    sw_wr(5'd7, 32'h0000_00F7); sw_wr(5'd24, 32'h2424_2424); sw_wr(5'd25, 32'h2525_2525);
    sw_wr(5'd4, 32'h1234_5678);
    rd_chk("R5 num0", 5'd0, 32'hDEAD_BEEE); rd_chk("R6 num2 bit0", 5'd2, 32'h1111_1112);
    rd_chk("R5 num1", 5'd1, 32'hCAFE_0001); rd_chk("R5 num3", 5'd3, 32'h0BAD_F00D);
    rd_chk("R5 num4", 5'd4, 32'h1234_5678); rd_chk("R5 num7", 5'd7, 32'h0000_00F7);
    rd_chk("R5 num24", 5'd24, 32'h2424_2424); rd_chk("R5 num25", 5'd25, 32'h2525_2525);
  endtask

  task automatic t_ident();
    rd_chk("R7 id", 5'd6, EXP_ID);
    sw_wr(5'd6, 32'hFFFF_FFFF);
    rd_chk("R7 id after write", 5'd6, EXP_ID);
  endtask

  task automatic t_rsv();
    sw_wr(5'd8, 32'h8888_8888); sw_wr(5'd9, 32'h9999_9999); sw_wr(5'd23, 32'h2323_2323);
    sw_wr(5'd26, 32'h2626_2626); sw_wr(5'd30, 32'h3030_3030); sw_wr(5'd31, 32'h3131_3131);
    rd_chk("R8 num8", 5'd8, 0);   rd_chk("R8 num9", 5'd9, 0);   rd_chk("R8 num23", 5'd23, 0);
    rd_chk("R8 num26", 5'd26, 0); rd_chk("R8 num30", 5'd30, 0); rd_chk("R8 num31", 5'd31, 0);
    rd_chk("R8 num7 kept", 5'd7, 32'h0000_00F7); rd_chk("R8 num24 kept", 5'd24, 32'h2424_2424);
    rd_chk("R8 num25 kept", 5'd25, 32'h2525_2525); rd_chk("R8 num4 kept", 5'd4, 32'h1234_5678);
    cmp("R8 exc_pc kept", exc_pc_q, 32'hDEAD_BEEE); cmp("R8 fat_psw kept", fat_psw_q, 32'h0BAD_F00D);
  endtask

  task automatic t_status();
    cur_psw = 32'h0000_0055;
    sw_wr(5'd5, 32'hFFFF_0000);
    rd_chk("R9 status", 5'd5, 32'h0000_0055);
    cur_psw = 32'h0000_0066;
    rd_chk("R9 status follows", 5'd5, 32'h0000_0066);
  endtask

  task automatic t_collide();
    @(negedge clk); cur_pc = 32'h0000_ABC0; cur_psw = 32'h7;
    wr_en = 1; wr_num = 5'd0; wr_data = 32'h0000_0001; exc_code = 16'h0077; exc_take = 1;
    @(negedge clk); wr_en = 0; exc_take = 0;
    cmp("R10 exc_pc event wins", exc_pc_q, 32'h0000_ABC0);
    @(negedge clk); wr_en = 1; wr_num = 5'd4; wr_data = 32'hBEEF_0000; exc_code = 16'h0005; exc_take = 1;
    @(negedge clk); wr_en = 0; exc_take = 0;
    cmp("R10 cause low event/high sw", cause_q, 32'hBEEF_0005);
    @(negedge clk); wr_en = 1; wr_num = 5'd4; wr_data = 32'h0000_1111; fat_code = 16'h00F1; fat_take = 1;
    @(negedge clk); wr_en = 0; fat_take = 0;
    cmp("R10 cause high event/low sw", cause_q, 32'h00F1_1111);
  endtask

  task automatic t_trap();
    sw_wr(5'd25, 32'h0000_2000);
    cur_pc = 32'h0000_2000; pc_vld = 1; #1;
    cmp("R11 hit", {31'd0, trap_hit}, 1);
    cur_pc = 32'h0000_2002; #1;
    cmp("R11 miss", {31'd0, trap_hit}, 0);
    cur_pc = 32'h0000_2000; pc_vld = 0; #1;
    cmp("R11 unqualified", {31'd0, trap_hit}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exc();
    t_fat();
    t_both();
    t_sw();
    t_ident();
    t_rsv();
    t_status();
    t_collide();
    t_trap();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule